// File: doc/BRIEF.md
# Paced SPI DAC Command Streamer

This block drives a dual-channel 12-bit DAC over a three-wire SPI link. An internal sample-period counter sets the output rate. Each time the counter expires, the block takes a 16-bit sample and a channel select, packs them with fixed control bits into a 16-bit command word, and clocks the word out in SPI mode 0, MSB first, with chip select held low. Chip select then goes high and stays high for a minimum idle time. The DAC updates its output on that rising edge, so every word is committed on its own.

A test mode replaces the sample input with an alternating full-scale and zero pattern, which gives a square wave at half the tick rate. If the counter expires while a word is still in flight, that tick is dropped and a sticky overrun flag is raised until software clears it.

Top module: `dac_word_streamer`

## Requirements
- R1: The command word is {chan_sel, 1'b0, 2'b11, sample[15:4]}: bit 15 is the channel (0 = A, 1 = B), bit 14 is 0, bits 13:12 are 1, and bits 11:0 are the top 12 bits of the sample.
- R2: SCK idles low. MOSI changes only while SCK is low and holds steady while SCK is high. The receiver samples on the rising edge, bit 15 first.
- R3: Chip select falls one clock after an accepted tick. The first SCK rise comes HALF_DIV clocks later. Chip select stays low for exactly 32*HALF_DIV clocks and rises on the last falling SCK edge.
- R4: Chip select stays high for at least 4*HALF_DIV clocks (two SCK periods) between words.
- R5: While enable is high, a tick occurs every period_m1+1 clocks, and each tick accepted while idle starts exactly one word.
- R6: With square_mode high, successive words carry samples 0x0000 and 0xFFFF in turn. The level starts at 0 after reset and advances only on accepted ticks.
- R7: A tick that arrives while busy is dropped, so no word starts for it. It also sets overrun, which stays set until cleared.
- R8: A one-cycle pulse on ovr_clr clears overrun, unless a tick is dropped in the same cycle.
- R9: Reset leaves cs_n high, sck low, busy low and overrun low.
- R10: While enable is low, no word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| enable | input | 1 | Runs the sample-period counter |
| period_m1 | input | PERIOD_W | Sample period in clocks, minus one |
| sample_in | input | 16 | Sample to send |
| chan_sel | input | 1 | Output channel: 0 = A, 1 = B |
| square_mode | input | 1 | Send the alternating 0x0000/0xFFFF test pattern instead of sample_in |
| ovr_clr | input | 1 | Clears the overrun flag |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A word or its idle gap is in progress |
| overrun | output | 1 | Sticky flag: a tick was dropped |

## Verification
Every timing result is measured from the clock edge that accepts a tick:
- chip select falls after that edge;
- the first SCK rise follows HALF_DIV clocks later;
- chip select rises 32*HALF_DIV clocks after it fell;
- the next fall comes period_m1+1 clocks after the previous one, or twice that when a tick is dropped.

The bench counts clocks on the falling clock edge and stamps each chip-select and SCK transition with that count, so every interval is compared exactly. Words are captured on SCK rises. Stimulus changes only just after chip select rises, well before the next tick, so the expected word always reflects the inputs seen by the accepting edge. Flag checks are made one clock after a clear pulse, or after several whole frames have passed.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 12;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_GAP   = 2'd2
  } shift_state_e;

  // channel, unbuffered reference (0), gain x1 (1), active (1), data
  function automatic logic [WORD_W-1:0] pack_cmd(input logic chan,
                                                 input logic [15:0] smp);
    return {chan, 1'b0, 1'b1, 1'b1, smp[15:16-DATA_W]};
  endfunction
endpackage

// File: rtl/dac_period_timer.sv
module dac_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period_m1,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                expire;

  assign expire = enable && (cnt_q >= period_m1);
  assign tick   = expire;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)     cnt_d = '0;
    else if (expire) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_cmd_builder.sv
module dac_cmd_builder
  import dac_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              square_mode,
  input  logic              chan_sel,
  input  logic [15:0]       sample_in,
  output logic [WORD_W-1:0] word
);
  logic        level_q, level_d;
  logic [15:0] smp;

  assign smp  = square_mode ? {16{level_q}} : sample_in;
  assign word = pack_cmd(chan_sel, smp);

  always_comb begin
    level_d = level_q;
    if (accept && square_mode) level_d = ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end
endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter
  import dac_stream_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam int GAP_CYC = 4 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_W);

  shift_state_e      st_q, st_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sck_q, sck_d, cs_q, cs_d;
  logic              half_done;

  assign half_done = (div_q == DIV_W'(HALF_DIV - 1));
  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = sh_q[WORD_W-1];
  assign busy = (st_q != SH_IDLE);

  always_comb begin
    st_d  = st_q;
    div_d = div_q;
    gap_d = gap_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    sck_d = sck_q;
    cs_d  = cs_q;
    unique case (st_q)
      SH_IDLE: if (start) begin
        st_d  = SH_SHIFT;
        cs_d  = 1'b0;
        sh_d  = word_in;
        bit_d = '0;
        div_d = '0;
        sck_d = 1'b0;
      end
      SH_SHIFT: begin
        if (half_done) begin
          div_d = '0;
          if (!sck_q) begin
            sck_d = 1'b1;
          end else begin
            sck_d = 1'b0;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              cs_d  = 1'b1;
              st_d  = SH_GAP;
              gap_d = '0;
            end else begin
              sh_d  = {sh_q[WORD_W-2:0], 1'b0};
              bit_d = bit_q + 1'b1;
            end
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      SH_GAP: begin
        if (gap_q == GAP_W'(GAP_CYC - 1)) st_d = SH_IDLE;
        else                               gap_d = gap_q + 1'b1;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      div_q <= '0;
      gap_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      div_q <= div_d;
      gap_q <= gap_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      sck_q <= sck_d;
      cs_q  <= cs_d;
    end
  end
endmodule

// File: rtl/dac_word_streamer.sv
module dac_word_streamer
  import dac_stream_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period_m1,
  input  logic [15:0]         sample_in,
  input  logic                chan_sel,
  input  logic                square_mode,
  input  logic                ovr_clr,
  output logic                sck,
  output logic                mosi,
  output logic                cs_n,
  output logic                busy,
  output logic                overrun
);
  logic              tick, accept, drop;
  logic              ovr_q, ovr_d;
  logic [WORD_W-1:0] word;

  assign accept  = tick && !busy;
  assign drop    = tick && busy;
  assign overrun = ovr_q;

  dac_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_m1(period_m1), .tick(tick)
  );

  dac_cmd_builder u_build (
    .clk(clk), .rst_n(rst_n), .accept(accept), .square_mode(square_mode),
    .chan_sel(chan_sel), .sample_in(sample_in), .word(word)
  );

  dac_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .word_in(word),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (drop)         ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end
endmodule

// File: rtl/dac_stream_checks.sv
module dac_stream_checks #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic overrun,
  input logic ovr_clr
);
  localparam int GAP_MIN = 4 * HALF_DIV;
  localparam int GC_W    = $clog2(GAP_MIN + 1) + 1;

  logic [GC_W-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          high_cnt <= GC_W'(GAP_MIN);
    else if (!cs_n)                      high_cnt <= '0;
    else if (high_cnt < GC_W'(GAP_MIN))  high_cnt <= high_cnt + 1'b1;
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R3
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R4
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt >= GC_W'(GAP_MIN)));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !busy) |=> !overrun);
endmodule

bind dac_word_streamer dac_stream_checks #(.HALF_DIV(HALF_DIV)) u_checks (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .overrun(overrun), .ovr_clr(ovr_clr)
);

// File: tb/dac_word_streamer_test.sv
module dac_word_streamer_test;
  localparam int H  = 4;
  localparam int PW = 16;

  logic          clk, rst_n, enable, chan_sel, square_mode, ovr_clr;
  logic [PW-1:0] period_m1;
  logic [15:0]   sample_in;
  logic          sck, mosi, cs_n, busy, overrun;

  int n_run, n_fail;
  int cyc, t_fall, t_rise, prev_fall, frames;
  int per_mode, skip_iv;
  logic        sq_lvl;
  logic [15:0] cap, exp_w;
  int          nbits;

  dac_word_streamer #(.PERIOD_W(PW), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_m1(period_m1),
    .sample_in(sample_in), .chan_sel(chan_sel), .square_mode(square_mode),
    .ovr_clr(ovr_clr), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) cyc = cyc + 1;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mk_word(input logic ch, input logic [15:0] s);
    return {ch, 1'b0, 2'b11, s[15:4]};
  endfunction

  // frame start: compute expected word, check the interval (R5, R7), gap (R4)
  always @(negedge cs_n) begin
    if (rst_n) begin
      t_fall = cyc;
      nbits  = 0;
      cap    = '0;
      if (square_mode) begin
        exp_w  = mk_word(chan_sel, {16{sq_lvl}});
        sq_lvl = ~sq_lvl;
      end else begin
        exp_w = mk_word(chan_sel, sample_in);
      end
      if (frames > 0) begin
        check(t_fall - t_rise >= 4*H, "R4 cs high gap", t_fall - t_rise, 4*H);
        if (skip_iv == 0 && per_mode == 1)
          check(t_fall - prev_fall == int'(period_m1) + 1, "R5 word period",
                t_fall - prev_fall, int'(period_m1) + 1);
        if (skip_iv == 0 && per_mode == 2)
          check(t_fall - prev_fall == 2*(int'(period_m1) + 1), "R7 tick dropped",
                t_fall - prev_fall, 2*(int'(period_m1) + 1));
      end
      if (skip_iv > 0) skip_iv--;
      prev_fall = t_fall;
    end
  end

  always @(posedge sck) begin
    if (nbits == 0)
      check(cyc - t_fall == H, "R3 first sck rise delay", cyc - t_fall, H);
    cap   = {cap[14:0], mosi};
    nbits = nbits + 1;
  end

  always @(posedge cs_n) begin
    if (rst_n && frames >= 0 && nbits > 0) begin
      t_rise = cyc;
      frames++;
      check(nbits == 16, "R2 bit count", nbits, 16);
      check(cap == exp_w, square_mode ? "R6 square word" : "R1 word format",
            cap, exp_w);
      check(t_rise - t_fall == 32*H, "R3 cs low time", t_rise - t_fall, 32*H);
    end
  end

  task automatic wait_frame();
    @(posedge cs_n);
    @(negedge clk);
  endtask

  task automatic set_period(input int p_m1, input int mode);
    period_m1 = PW'(p_m1);
    per_mode  = mode;
    skip_iv   = 1;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int f0;
    n_run = 0; n_fail = 0; cyc = 0; frames = 0; t_rise = 0; t_fall = 0;
    prev_fall = 0; per_mode = 0; skip_iv = 1; sq_lvl = 1'b0; nbits = 0;
    cap = '0; exp_w = '0;
    rst_n = 1'b0; enable = 1'b0; chan_sel = 1'b0; square_mode = 1'b0;
    ovr_clr = 1'b0; period_m1 = PW'(199); sample_in = 16'h0;
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1, "R9 reset cs_n", cs_n, 1);
    check(sck == 1'b0, "R9 reset sck", sck, 0);
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(overrun == 1'b0, "R9 reset overrun", overrun, 0);
    rst_n = 1'b1;

    repeat (600) @(negedge clk);
    check(frames == 0 && cs_n, "R10 disabled no words", frames, 0);

    // directed corner words
    set_period(199, 1);
    chan_sel = 1'b0; sample_in = 16'hABCD; enable = 1'b1;
    wait_frame();
    chan_sel = 1'b1; sample_in = 16'hFFFF; wait_frame();
    chan_sel = 1'b0; sample_in = 16'h000F; wait_frame();
    chan_sel = 1'b0; sample_in = 16'h0010; wait_frame();
    chan_sel = 1'b1; sample_in = 16'h8000; wait_frame();

    // constrained random words and periods
    void'($urandom(32'd1234));
    for (int i = 0; i < 14; i++) begin
      chan_sel  = 1'($urandom_range(0, 1));
      sample_in = 16'($urandom);
      if (i % 5 == 0) set_period(int'($urandom_range(150, 320)), 1);
      wait_frame();
    end

    // square wave test pattern
    square_mode = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chan_sel = 1'(i);
      wait_frame();
    end
    square_mode = 1'b0; sample_in = 16'h1234; chan_sel = 1'b1;
    wait_frame();

    // boundary: period 145 keeps up, period 144 overruns
    set_period(144, 1);
    repeat (4) wait_frame();
    check(overrun == 1'b0, "R7 no overrun at period 145", overrun, 0);
    set_period(143, 2);
    repeat (4) wait_frame();
    check(overrun == 1'b1, "R7 overrun at period 144", overrun, 1);
    set_period(144, 1);
    repeat (3) wait_frame();
    check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    check(overrun == 1'b0, "R8 overrun cleared", overrun, 0);
    repeat (3) wait_frame();
    check(overrun == 1'b0, "R8 stays clear", overrun, 0);

    // disable stops output
    enable = 1'b0;
    repeat (200) @(negedge clk);
    f0 = frames;
    repeat (800) @(negedge clk);
    check(frames == f0 && cs_n, "R10 no words after disable", frames, f0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule